// File: doc/BRIEF.md
# Power-Down Hold Controller

This block implements the logical side of a device-wide power-down mode for a programmable logic array. Two request pins ask for power-down, and a static configuration bit decides whether the feature exists at all. When the feature is switched on and either pin is high, the block freezes three things: the input view that the array sees, the array's internal logic signals, and the pad output data together with its enables. Any input activity during that time is hidden from the array. When both requests are low again, the freeze ends on the following clock edge.

When the feature is switched on, the two request pins are taken out of ordinary logic use. Their values are masked from the array, and the output enables of their own cells are forced off. When the feature is switched off, the pins pass through as ordinary signals and never cause a freeze. A status flag reports whether the hold is in force.

Top module: `pwrdn_hold`

## Requirements
- R1: After reset, `pdActive` is 0 and every view output (`arrayIn`, `heldSig`, `padOut`, `padOe`) equals its live input.
- R2: With `pdEnable` low, the request pins never set `pdActive`, and `reqLogic` equals `{pdReq1, pdReq0}` (bit 0 is `pdReq0`).
- R3: With `pdEnable` high, `pdActive` is 1 in the cycle after any clock edge that samples `pdReq0` or `pdReq1` high, whether one pin or both are high.
- R4: While `pdActive` is 1, `arrayIn` holds the `liveIn` value sampled at the edge that set `pdActive`, whatever `liveIn` does afterwards.
- R5: While `pdActive` is 1, `heldSig` holds the `coreSig` value sampled at the entry edge.
- R6: While `pdActive` is 1, `padOut` and `padOe` both hold their entry values, so no pad changes between driven and high-impedance.
- R7: The first clock edge that samples both requests low, or `pdEnable` low, clears `pdActive`. From that cycle on, all views follow the live inputs.
- R8: With `pdEnable` high, `reqLogic` is 0 and `reqPadOe` is 0 whatever the pins and `reqCellOe` are. With `pdEnable` low, `reqPadOe` equals `reqCellOe`.
- R9: While `pdActive` is 0, every view output equals its live input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Array clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pdEnable | input | 1 | Static option that turns the power-down feature on |
| pdReq0 | input | 1 | First power-down request pin |
| pdReq1 | input | 1 | Second power-down request pin |
| liveIn | input | IN_W | Live values from the input pads |
| coreSig | input | SIG_W | Live internal logic signals of the array |
| coreOut | input | OUT_W | Output data produced by the array |
| coreOe | input | OUT_W | Output enables produced by the array |
| reqCellOe | input | 2 | Output enables of the two request pins' own cells |
| arrayIn | output | IN_W | Input view presented to the array |
| heldSig | output | SIG_W | Internal signal view, frozen during power-down |
| padOut | output | OUT_W | Output data sent to the pads |
| padOe | output | OUT_W | Output enables sent to the pads |
| reqLogic | output | 2 | Request pins as ordinary logic inputs, masked while the feature is on |
| reqPadOe | output | 2 | Pad enables of the request pins, forced off while the feature is on |
| pdActive | output | 1 | High while the hold is in force |

## Verification
The properties assume that `pdEnable` is a static option: it is set before or during reset and is not expected to change in the middle of a hold. They also assume that every input is synchronous to `clk`, so the request pins count only as sampled at a rising edge. The stimulus changes inputs only on the falling clock edge. It changes `pdEnable` only while both requests are low, and while a hold is in force it varies the live data widely, so that any leak through the freeze appears at the ports.

// File: rtl/pd_pkg.sv
package pd_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic capture;  // track live values into the hold registers
    logic useHeld;  // present held values instead of live ones
  } holdStrobe_t;
endpackage

// File: rtl/pd_ctrl.sv
module pd_ctrl
  import pd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pdEnable,
  input  logic        pdReq0,
  input  logic        pdReq1,
  input  logic [1:0]  reqCellOe,
  output logic        pdActive,
  output logic [1:0]  reqLogic,
  output logic [1:0]  reqPadOe,
  output holdStrobe_t strobe
);
  logic pdWant;

  always_comb pdWant = pdEnable & (pdReq0 | pdReq1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pdActive <= 1'b0;
    else       pdActive <= pdWant;
  end

  always_comb begin
    strobe.capture = ~pdActive;
    strobe.useHeld = pdActive;
  end

  // request pins leave normal logic use while the feature is on
  always_comb begin
    reqLogic = pdEnable ? 2'b00 : {pdReq1, pdReq0};
    reqPadOe = pdEnable ? 2'b00 : reqCellOe;
  end
endmodule

// File: rtl/pd_hold_bank.sv
module pd_hold_bank
  import pd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  holdStrobe_t       strobe,
  input  logic [WIDTH-1:0]  live,
  output logic [WIDTH-1:0]  view
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_cell
      logic heldBit;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              heldBit <= 1'b0;
        else if (strobe.capture) heldBit <= live[b];
      end
      always_comb view[b] = strobe.useHeld ? heldBit : live[b];
    end
  endgenerate
endmodule

// File: rtl/pd_datapath.sv
module pd_datapath
  import pd_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int SIG_W = 16,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  holdStrobe_t      strobe,
  input  logic [IN_W-1:0]  liveIn,
  input  logic [SIG_W-1:0] coreSig,
  input  logic [OUT_W-1:0] coreOut,
  input  logic [OUT_W-1:0] coreOe,
  output logic [IN_W-1:0]  arrayIn,
  output logic [SIG_W-1:0] heldSig,
  output logic [OUT_W-1:0] padOut,
  output logic [OUT_W-1:0] padOe
);
  localparam int PAD_W = 2 * OUT_W;

  logic [PAD_W-1:0] padLive;
  logic [PAD_W-1:0] padView;

  // output data and enables share one bank so they freeze together
  always_comb padLive = {coreOe, coreOut};

  pd_hold_bank #(.WIDTH(IN_W)) uInBank (
    .clk(clk), .rstN(rstN), .strobe(strobe), .live(liveIn), .view(arrayIn)
  );

  pd_hold_bank #(.WIDTH(SIG_W)) uSigBank (
    .clk(clk), .rstN(rstN), .strobe(strobe), .live(coreSig), .view(heldSig)
  );

  pd_hold_bank #(.WIDTH(PAD_W)) uPadBank (
    .clk(clk), .rstN(rstN), .strobe(strobe), .live(padLive), .view(padView)
  );

  always_comb begin
    padOut = padView[OUT_W-1:0];
    padOe  = padView[PAD_W-1:OUT_W];
  end
endmodule

// File: rtl/pwrdn_hold.sv
module pwrdn_hold
  import pd_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int SIG_W = 16,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pdEnable,
  input  logic             pdReq0,
  input  logic             pdReq1,
  input  logic [IN_W-1:0]  liveIn,
  input  logic [SIG_W-1:0] coreSig,
  input  logic [OUT_W-1:0] coreOut,
  input  logic [OUT_W-1:0] coreOe,
  input  logic [1:0]       reqCellOe,
  output logic [IN_W-1:0]  arrayIn,
  output logic [SIG_W-1:0] heldSig,
  output logic [OUT_W-1:0] padOut,
  output logic [OUT_W-1:0] padOe,
  output logic [1:0]       reqLogic,
  output logic [1:0]       reqPadOe,
  output logic             pdActive
);
  holdStrobe_t strobe;

  pd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .pdEnable(pdEnable), .pdReq0(pdReq0),
    .pdReq1(pdReq1), .reqCellOe(reqCellOe), .pdActive(pdActive),
    .reqLogic(reqLogic), .reqPadOe(reqPadOe), .strobe(strobe)
  );

  pd_datapath #(.IN_W(IN_W), .SIG_W(SIG_W), .OUT_W(OUT_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .liveIn(liveIn),
    .coreSig(coreSig), .coreOut(coreOut), .coreOe(coreOe),
    .arrayIn(arrayIn), .heldSig(heldSig), .padOut(padOut), .padOe(padOe)
  );
endmodule

// File: rtl/pwrdn_hold_chk.sv
module pwrdn_hold_chk #(
  parameter int IN_W  = 8,
  parameter int SIG_W = 16,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             pdEnable,
  input logic             pdReq0,
  input logic             pdReq1,
  input logic [IN_W-1:0]  liveIn,
  input logic [SIG_W-1:0] coreSig,
  input logic [OUT_W-1:0] coreOut,
  input logic [OUT_W-1:0] coreOe,
  input logic [1:0]       reqCellOe,
  input logic [IN_W-1:0]  arrayIn,
  input logic [SIG_W-1:0] heldSig,
  input logic [OUT_W-1:0] padOut,
  input logic [OUT_W-1:0] padOe,
  input logic [1:0]       reqLogic,
  input logic [1:0]       reqPadOe,
  input logic             pdActive
);
  // R3
  enter_pd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pdEnable && (pdReq0 || pdReq1)) |=> pdActive);
  // R2
  no_pd_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pdEnable |=> !pdActive);
  // R7
  exit_pd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pdReq0 && !pdReq1) |=> !pdActive);
  // R4
  in_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pdActive && $past(pdActive)) |-> $stable(arrayIn));
  // R5
  sig_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pdActive && $past(pdActive)) |-> $stable(heldSig));
  // R6
  pad_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pdActive && $past(pdActive)) |-> ($stable(padOut) && $stable(padOe)));
  // R8
  req_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    pdEnable |-> (reqLogic == 2'b00 && reqPadOe == 2'b00));
  // R9
  live_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pdActive |-> (arrayIn == liveIn && heldSig == coreSig &&
                   padOut == coreOut && padOe == coreOe));
endmodule

bind pwrdn_hold pwrdn_hold_chk #(.IN_W(IN_W), .SIG_W(SIG_W), .OUT_W(OUT_W)) uChk (
  .clk(clk), .rstN(rstN), .pdEnable(pdEnable), .pdReq0(pdReq0),
  .pdReq1(pdReq1), .liveIn(liveIn), .coreSig(coreSig), .coreOut(coreOut),
  .coreOe(coreOe), .reqCellOe(reqCellOe), .arrayIn(arrayIn),
  .heldSig(heldSig), .padOut(padOut), .padOe(padOe), .reqLogic(reqLogic),
  .reqPadOe(reqPadOe), .pdActive(pdActive)
);

// File: tb/sim_pwrdn_hold.sv
`timescale 1ns/1ps
module sim_pwrdn_hold;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pdEnable = 1'b0, pdReq0 = 1'b0, pdReq1 = 1'b0;
  logic [7:0]  liveIn = '0;
  logic [15:0] coreSig = '0;
  logic [7:0]  coreOut = '0, coreOe = '0;
  logic [1:0]  reqCellOe = '0;
  logic [7:0]  arrayIn;
  logic [15:0] heldSig;
  logic [7:0]  padOut, padOe;
  logic [1:0]  reqLogic, reqPadOe;
  logic        pdActive;

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct {
    logic        act;
    logic [7:0]  ain;
    logic [15:0] sig;
    logic [7:0]  pout, poe;
    logic [1:0]  rl, roe;
    string       tag;
  } expItem_t;

  expItem_t q[$];

  // bench model state
  logic        mAct = 0;
  logic [7:0]  mIn = 0, mOut = 0, mOe = 0;
  logic [15:0] mSig = 0;

  always #10 clk = ~clk;

  pwrdn_hold u0 (
    .clk(clk), .rstN(rstN), .pdEnable(pdEnable), .pdReq0(pdReq0),
    .pdReq1(pdReq1), .liveIn(liveIn), .coreSig(coreSig), .coreOut(coreOut),
    .coreOe(coreOe), .reqCellOe(reqCellOe), .arrayIn(arrayIn),
    .heldSig(heldSig), .padOut(padOut), .padOe(padOe), .reqLogic(reqLogic),
    .reqPadOe(reqPadOe), .pdActive(pdActive)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic r0, input logic r1,
                      input logic [7:0] i, input logic [15:0] s,
                      input logic [7:0] o, input logic [7:0] oe,
                      input logic [1:0] rco, input string tag);
    expItem_t e;
    @(negedge clk);
    pdEnable = en; pdReq0 = r0; pdReq1 = r1; liveIn = i; coreSig = s;
    coreOut = o; coreOe = oe; reqCellOe = rco;
    if (!mAct) begin mIn = i; mSig = s; mOut = o; mOe = oe; end
    mAct = en & (r0 | r1);
    e.act  = mAct;
    e.ain  = mAct ? mIn  : i;
    e.sig  = mAct ? mSig : s;
    e.pout = mAct ? mOut : o;
    e.poe  = mAct ? mOe  : oe;
    e.rl   = en ? 2'b00 : {r1, r0};
    e.roe  = en ? 2'b00 : rco;
    e.tag  = tag;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        expItem_t e;
        e = q.pop_front();
        check(e.tag, "pdActive", 16'(pdActive), 16'(e.act));
        check(e.tag, "arrayIn",  16'(arrayIn),  16'(e.ain));
        check(e.tag, "heldSig",  heldSig,       e.sig);
        check(e.tag, "padOut",   16'(padOut),   16'(e.pout));
        check(e.tag, "padOe",    16'(padOe),    16'(e.poe));
        check(e.tag, "reqLogic", 16'(reqLogic), 16'(e.rl));
        check(e.tag, "reqPadOe", 16'(reqPadOe), 16'(e.roe));
      end
    end
  end

  // watchdog
  initial begin
    #2000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    liveIn = 8'h5a; coreSig = 16'h1234; coreOut = 8'h0f; coreOe = 8'hf0;
    #25;
    // R1: reset state
    check("R1", "pdActive", 16'(pdActive), 16'h0);
    check("R1", "arrayIn", 16'(arrayIn), 16'h5a);
    check("R1", "padOe", 16'(padOe), 16'hf0);
    @(negedge clk); rstN = 1'b1;

    // R2: feature off, requests are ordinary signals
    step(0, 1, 0, 8'h11, 16'h0101, 8'h01, 8'hff, 2'b11, "R2");
    step(0, 1, 1, 8'h22, 16'h0202, 8'h02, 8'hff, 2'b01, "R2");
    step(0, 0, 1, 8'h33, 16'h0303, 8'h03, 8'h0f, 2'b10, "R2");
    // R9: live passthrough with feature on, no request
    step(1, 0, 0, 8'h44, 16'h0404, 8'h04, 8'h3c, 2'b11, "R9");
    step(1, 0, 0, 8'h45, 16'h0405, 8'h05, 8'h3d, 2'b11, "R8");
    // R3: enter through pin 0
    step(1, 1, 0, 8'hA5, 16'hBEEF, 8'hC3, 8'h81, 2'b11, "R3");
    // R4 R5 R6: hold while live values move
    step(1, 1, 0, 8'h00, 16'h0000, 8'h00, 8'h00, 2'b11, "R4");
    step(1, 0, 1, 8'hff, 16'hffff, 8'hff, 8'hff, 2'b11, "R5");
    step(1, 1, 1, 8'h3c, 16'h5555, 8'h66, 8'h7e, 2'b11, "R6");
    // R7: exit
    step(1, 0, 0, 8'h99, 16'h9999, 8'h98, 8'h97, 2'b00, "R7");
    step(1, 0, 0, 8'h9a, 16'h999a, 8'h9b, 8'h9c, 2'b00, "R7");
    // R3: enter through pin 1, then both
    step(1, 0, 1, 8'h71, 16'h7171, 8'h72, 8'h73, 2'b01, "R3");
    step(1, 1, 1, 8'h0e, 16'h0e0e, 8'h0d, 8'h0c, 2'b10, "R6");
    step(1, 0, 0, 8'h61, 16'h6161, 8'h62, 8'h63, 2'b11, "R7");
    // R3: one-cycle request pulse
    step(1, 1, 1, 8'hd1, 16'hd1d1, 8'hd2, 8'hd3, 2'b11, "R3");
    step(1, 0, 0, 8'he1, 16'he1e1, 8'he2, 8'he3, 2'b11, "R7");
    // R2: back to feature off
    step(0, 1, 1, 8'hf1, 16'hf1f1, 8'hf2, 8'hf3, 2'b11, "R2");
    step(0, 0, 0, 8'hf4, 16'hf4f4, 8'hf5, 8'hf6, 2'b00, "R9");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule